// File: doc/BRIEF.md
# Threshold Byte FIFO Pair with Drain Signalling

This block sits between a register port and a serial bus shift engine. It holds two byte FIFOs: one carries bytes from the host toward the engine (transmit) and one carries bytes from the engine toward the host (receive). Their depth is fixed when the block is built, as eight entries shifted left by a two-bit size code. Software programs a transfer threshold for each direction. While a transfer is running, the block raises a ready event whenever a full threshold of bytes can be moved in one burst. This means threshold free slots for transmit, or threshold stored bytes for receive, with at least that many bytes still owed by the transfer.

Near the end of a transfer, the bytes still owed can fall below the threshold. The block then raises a separate drain event as soon as the FIFO can take, or hand over, all of that remainder. The host can therefore move the partial final burst without waiting for a full threshold that will never come. A status word reports the size code and a six-bit level. While a drain event is up, the level is the exact number of bytes to move. Otherwise it is the occupancy of the FIFO for the running direction. Each FIFO can be emptied in one cycle through a self-clearing bit of the configuration word.

The transfer is started by loading a byte count and a direction. The count goes down by one for every byte the host moves in that direction.

Top module: `byte_fifo_pair`

## Requirements
- R1: The FIFO depth is 8 << SIZE_CODE. Status bits 15:14 read back SIZE_CODE. Each FIFO holds exactly that many bytes.
- R2: Each FIFO returns bytes in the order they entered. Its output is visible without a read cycle.
- R3: A push into a full FIFO is dropped and a pop from an empty FIFO is ignored. Neither changes the FIFO's contents or level.
- R4: Configuration word layout: bits 13:8 hold the receive threshold minus one, bits 5:0 hold the transmit threshold minus one, bit 15 is the receive DMA enable and bit 7 is the transmit DMA enable. All of these read back as written. Bits 14 and 6 always read 0. The reset value is 0.
- R5: Writing 1 to configuration bit 14 empties the receive FIFO, and writing 1 to bit 6 empties the transmit FIFO. The FIFO is empty from the next cycle on, and the other FIFO is untouched.
- R6: During a transmit transfer, tx_ready is 1 when the remaining count is at least the threshold and the transmit FIFO has at least that many free slots.
- R7: During a receive transfer, rx_ready is 1 when the remaining count is at least the threshold and the receive FIFO holds at least that many bytes.
- R8: A drain event is 1 when the remaining count is nonzero and below the threshold, and the FIFO can move the whole remainder (free slots for transmit, stored bytes for receive). A drain event is never high together with the ready event of the same direction.
- R9: Status bits 5:0 give the remaining count while a drain event is high. Otherwise they give the occupancy of the running direction's FIFO, saturated at 63. Status bits 13:6 read 0.
- R10: Loading a transfer sets the remaining count and the direction (xfer_is_tx = 1 for transmit). Each accepted host push (transmit) or host pop (receive) lowers the count by one. The count never goes below zero, and while it is zero no event is raised.
- R11: A programmed threshold above the depth acts as a threshold equal to the depth.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| cfg_we | input | 1 | Configuration word write strobe |
| cfg_wdata | input | 16 | Configuration word write data |
| cfg_rdata | output | 16 | Configuration word read-back |
| stat_rdata | output | 16 | Size code and level status word |
| xfer_load | input | 1 | Load a new transfer count and direction |
| xfer_is_tx | input | 1 | Direction of the loaded transfer, 1 = transmit |
| xfer_len | input | CW | Byte count of the loaded transfer |
| host_tx_we | input | 1 | Host pushes a byte into the transmit FIFO |
| host_tx_data | input | 8 | Byte pushed by the host |
| host_rx_re | input | 1 | Host pops a byte from the receive FIFO |
| host_rx_data | output | 8 | Head byte of the receive FIFO |
| eng_tx_re | input | 1 | Engine pops a byte from the transmit FIFO |
| eng_tx_data | output | 8 | Head byte of the transmit FIFO |
| eng_tx_empty | output | 1 | Transmit FIFO is empty |
| eng_rx_we | input | 1 | Engine pushes a byte into the receive FIFO |
| eng_rx_data | input | 8 | Byte pushed by the engine |
| eng_rx_full | output | 1 | Receive FIFO is full |
| tx_ready | output | 1 | A threshold burst can be pushed into the transmit FIFO |
| tx_drain | output | 1 | The transmit remainder can be pushed in one burst |
| rx_ready | output | 1 | A threshold burst can be popped from the receive FIFO |
| rx_drain | output | 1 | The receive remainder can be popped in one burst |

## Verification
The hardest condition to reach is an event decision at the far end of the count. The remaining count has to be driven to zero and then pushed on by further host moves, with the FIFO still holding enough bytes that a wrapped count would raise a ready event. The bench gets there by loading a two-byte receive transfer, popping both bytes, refilling the FIFO past the threshold, and popping once more. A second hard case is a transmit remainder that is smaller than the threshold but larger than the free space. A table of transfers reaches it by pushing almost a whole FIFO against a long count. The same table places other transfers on each side of the threshold and the depth.

// File: rtl/bfp_pkg.sv
package bfp_pkg;
   // Configuration word bit positions (decoded by the register port).
   localparam int CFG_RX_DMA = 15;
   localparam int CFG_RX_CLR = 14;
   localparam int CFG_RX_THR = 8;
   localparam int CFG_TX_DMA = 7;
   localparam int CFG_TX_CLR = 6;
   localparam int CFG_TX_THR = 0;
   localparam int THR_FW     = 6;
   // Status word layout.
   localparam int STAT_CODE  = 14;
   localparam int LVL_W      = 6;
   localparam int THR_W      = THR_FW + 1;

   typedef struct packed {
      logic              rx_dma;
      logic [THR_FW-1:0] rx_thr_m1;
      logic              tx_dma;
      logic [THR_FW-1:0] tx_thr_m1;
   } cfg_t;

   // Programmed value is threshold-1; result is clipped to the depth.
   function automatic logic [THR_W-1:0] eff_thr(input logic [THR_FW-1:0] m1,
                                                input int depth);
      logic [THR_W-1:0] t;
      t = {1'b0, m1} + THR_W'(1);
      if (int'(t) > depth) t = THR_W'(depth);
      return t;
   endfunction
endpackage

// File: rtl/bfp_fifo.sv
module bfp_fifo #(
   parameter int DEPTH = 16,
   parameter int DW    = 8,
   localparam int AW   = $clog2(DEPTH),
   localparam int CNTW = AW + 1
) (
   input  logic            clk,
   input  logic            rst_n,
   input  logic            clr,
   input  logic            push,
   input  logic [DW-1:0]   din,
   input  logic            pop,
   output logic [DW-1:0]   dout,
   output logic [CNTW-1:0] count,
   output logic            full,
   output logic            empty
);
   logic [DW-1:0] mem [DEPTH];
   logic [AW-1:0] wr_ptr, rd_ptr;
   logic          push_ok, pop_ok;

   initial begin
      assert (DEPTH >= 2 && (DEPTH & (DEPTH - 1)) == 0)
         else $error("bfp_fifo: DEPTH must be a power of two");
   end

   assign full    = (count == CNTW'(DEPTH));
   assign empty   = (count == '0);
   assign push_ok = push && !full;
   assign pop_ok  = pop && !empty;
   assign dout    = mem[rd_ptr];

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         wr_ptr <= '0;
         rd_ptr <= '0;
         count  <= '0;
      end else if (clr) begin
         wr_ptr <= '0;
         rd_ptr <= '0;
         count  <= '0;
      end else begin
         if (push_ok) wr_ptr <= wr_ptr + AW'(1);
         if (pop_ok)  rd_ptr <= rd_ptr + AW'(1);
         case ({push_ok, pop_ok})
            2'b10:   count <= count + CNTW'(1);
            2'b01:   count <= count - CNTW'(1);
            default: count <= count;
         endcase
      end
   end

   always_ff @(posedge clk) begin
      if (push_ok && !clr) mem[wr_ptr] <= din;
   end

   // R3: level never exceeds the depth
   p_count_bound_r3: assert property (@(posedge clk) disable iff (!rst_n)
      count <= CNTW'(DEPTH));
   // R3: a lone push into a full FIFO leaves the level alone
   p_push_full_ignored_r3: assert property (@(posedge clk) disable iff (!rst_n)
      (full && push && !pop && !clr) |=> (count == $past(count)));
   // R3: a lone pop from an empty FIFO leaves it empty
   p_pop_empty_ignored_r3: assert property (@(posedge clk) disable iff (!rst_n)
      (empty && pop && !push && !clr) |=> empty);
   // R5: clear takes effect at the next edge
   p_clear_empties_r5: assert property (@(posedge clk) disable iff (!rst_n)
      clr |=> empty);
endmodule

// File: rtl/bfp_cfg.sv
module bfp_cfg
   import bfp_pkg::*;
#(
   parameter int DEPTH = 16
) (
   input  logic             clk,
   input  logic             rst_n,
   input  logic             we,
   input  logic [15:0]      wdata,
   output logic [15:0]      rdata,
   output logic             clr_rx,
   output logic             clr_tx,
   output logic [THR_W-1:0] rx_thr,
   output logic [THR_W-1:0] tx_thr
);
   cfg_t cfg_q;

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         cfg_q <= '0;
      end else if (we) begin
         cfg_q.rx_dma    <= wdata[CFG_RX_DMA];
         cfg_q.rx_thr_m1 <= wdata[CFG_RX_THR +: THR_FW];
         cfg_q.tx_dma    <= wdata[CFG_TX_DMA];
         cfg_q.tx_thr_m1 <= wdata[CFG_TX_THR +: THR_FW];
      end
   end

   // Clear strobes act in the write cycle and never get stored.
   assign clr_rx = we && wdata[CFG_RX_CLR];
   assign clr_tx = we && wdata[CFG_TX_CLR];

   always_comb begin
      rdata                        = '0;
      rdata[CFG_RX_DMA]            = cfg_q.rx_dma;
      rdata[CFG_RX_THR +: THR_FW]  = cfg_q.rx_thr_m1;
      rdata[CFG_TX_DMA]            = cfg_q.tx_dma;
      rdata[CFG_TX_THR +: THR_FW]  = cfg_q.tx_thr_m1;
   end

   assign rx_thr = eff_thr(cfg_q.rx_thr_m1, DEPTH);
   assign tx_thr = eff_thr(cfg_q.tx_thr_m1, DEPTH);

   // R4: self-clearing bits never read back as 1 after a write
   p_clear_bits_zero_r4: assert property (@(posedge clk) disable iff (!rst_n)
      we |=> (rdata[CFG_RX_CLR] == 1'b0 && rdata[CFG_TX_CLR] == 1'b0));
   // R11: effective threshold stays within 1..DEPTH
   p_thr_range_r11: assert property (@(posedge clk) disable iff (!rst_n)
      (tx_thr != '0) && (int'(tx_thr) <= DEPTH) && (rx_thr != '0) && (int'(rx_thr) <= DEPTH));
endmodule

// File: rtl/bfp_xcnt.sv
module bfp_xcnt #(
   parameter int CW = 8
) (
   input  logic          clk,
   input  logic          rst_n,
   input  logic          load,
   input  logic          load_tx,
   input  logic [CW-1:0] len,
   input  logic          dec,
   output logic [CW-1:0] rem,
   output logic          dir_tx
);
   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         rem    <= '0;
         dir_tx <= 1'b0;
      end else if (load) begin
         rem    <= len;
         dir_tx <= load_tx;
      end else if (dec && rem != '0) begin
         rem    <= rem - CW'(1);
      end
   end

   // R10: count saturates at zero
   p_rem_floor_r10: assert property (@(posedge clk) disable iff (!rst_n)
      (rem == '0 && !load) |=> (rem == '0));
   // R10: one step down per accepted host move
   p_rem_step_r10: assert property (@(posedge clk) disable iff (!rst_n)
      (rem != '0 && dec && !load) |=> (rem == $past(rem) - CW'(1)));
endmodule

// File: rtl/bfp_evt.sv
module bfp_evt
   import bfp_pkg::*;
#(
   parameter int CW  = 8,
   parameter int AVW = 5
) (
   input  logic             clk,
   input  logic             rst_n,
   input  logic             active,
   input  logic [CW-1:0]    rem,
   input  logic [THR_W-1:0] thr,
   input  logic [AVW-1:0]   avail,
   output logic             ready,
   output logic             drain
);
   logic [CW-1:0] thr_w, av_w;

   initial begin
      assert (CW >= AVW && CW >= THR_W)
         else $error("bfp_evt: count width too narrow");
   end

   assign thr_w = CW'(thr);
   assign av_w  = CW'(avail);

   // Full burst: enough owed and enough room/data for a threshold.
   assign ready = active && (rem >= thr_w) && (av_w >= thr_w);
   // Partial final burst: remainder below threshold, all of it movable.
   assign drain = active && (rem != '0) && (rem < thr_w) && (av_w >= rem);

   // R8: ready and drain never coincide
   p_ready_drain_excl_r8: assert property (@(posedge clk) disable iff (!rst_n)
      !(ready && drain));
endmodule

// File: rtl/byte_fifo_pair.sv
module byte_fifo_pair
   import bfp_pkg::*;
#(
   parameter int SIZE_CODE = 1,
   parameter int CW        = 8,
   localparam int DEPTH    = 8 << SIZE_CODE,
   localparam int AW       = $clog2(DEPTH),
   localparam int CNTW     = AW + 1
) (
   input  logic          clk,
   input  logic          rst_n,
   input  logic          cfg_we,
   input  logic [15:0]   cfg_wdata,
   output logic [15:0]   cfg_rdata,
   output logic [15:0]   stat_rdata,
   input  logic          xfer_load,
   input  logic          xfer_is_tx,
   input  logic [CW-1:0] xfer_len,
   input  logic          host_tx_we,
   input  logic [7:0]    host_tx_data,
   input  logic          host_rx_re,
   output logic [7:0]    host_rx_data,
   input  logic          eng_tx_re,
   output logic [7:0]    eng_tx_data,
   output logic          eng_tx_empty,
   input  logic          eng_rx_we,
   input  logic [7:0]    eng_rx_data,
   output logic          eng_rx_full,
   output logic          tx_ready,
   output logic          tx_drain,
   output logic          rx_ready,
   output logic          rx_drain
);
   initial begin
      assert (SIZE_CODE >= 0 && SIZE_CODE <= 3)
         else $error("byte_fifo_pair: SIZE_CODE must be 0..3");
      assert (CW >= THR_W && CW >= CNTW)
         else $error("byte_fifo_pair: CW too narrow");
   end

   logic             clr_rx, clr_tx;
   logic [THR_W-1:0] rx_thr, tx_thr;
   logic [CNTW-1:0]  tx_cnt, rx_cnt;
   logic             tx_full, rx_empty;
   logic [CW-1:0]    rem;
   logic             dir_tx, dec;

   bfp_cfg #(.DEPTH(DEPTH)) u_cfg (
      .clk, .rst_n, .we(cfg_we), .wdata(cfg_wdata), .rdata(cfg_rdata),
      .clr_rx, .clr_tx, .rx_thr, .tx_thr);

   bfp_fifo #(.DEPTH(DEPTH), .DW(8)) u_txq (
      .clk, .rst_n, .clr(clr_tx), .push(host_tx_we), .din(host_tx_data),
      .pop(eng_tx_re), .dout(eng_tx_data), .count(tx_cnt),
      .full(tx_full), .empty(eng_tx_empty));

   bfp_fifo #(.DEPTH(DEPTH), .DW(8)) u_rxq (
      .clk, .rst_n, .clr(clr_rx), .push(eng_rx_we), .din(eng_rx_data),
      .pop(host_rx_re), .dout(host_rx_data), .count(rx_cnt),
      .full(eng_rx_full), .empty(rx_empty));

   // Only host-side moves in the running direction consume the count.
   assign dec = dir_tx ? (host_tx_we && !tx_full && !clr_tx)
                       : (host_rx_re && !rx_empty && !clr_rx);

   bfp_xcnt #(.CW(CW)) u_xcnt (
      .clk, .rst_n, .load(xfer_load), .load_tx(xfer_is_tx), .len(xfer_len),
      .dec, .rem, .dir_tx);

   // Index 0: transmit (free slots), index 1: receive (stored bytes).
   logic [1:0]       act, rdy, drn;
   logic [THR_W-1:0] thr_a [2];
   logic [CNTW-1:0]  av_a  [2];

   assign act[0]   = dir_tx;
   assign act[1]   = !dir_tx;
   assign thr_a[0] = tx_thr;
   assign thr_a[1] = rx_thr;
   assign av_a[0]  = CNTW'(DEPTH) - tx_cnt;
   assign av_a[1]  = rx_cnt;

   for (genvar d = 0; d < 2; d++) begin : g_evt
      bfp_evt #(.CW(CW), .AVW(CNTW)) u_evt (
         .clk, .rst_n, .active(act[d]), .rem, .thr(thr_a[d]),
         .avail(av_a[d]), .ready(rdy[d]), .drain(drn[d]));
   end

   assign tx_ready = rdy[0];
   assign tx_drain = drn[0];
   assign rx_ready = rdy[1];
   assign rx_drain = drn[1];

   // Status level: remainder while draining, else running-direction occupancy.
   logic [CNTW-1:0]  occ;
   logic [LVL_W-1:0] occ_lvl, lvl;

   assign occ = dir_tx ? tx_cnt : rx_cnt;

   if (CNTW > LVL_W) begin : g_lvl_sat
      assign occ_lvl = (occ > CNTW'((1 << LVL_W) - 1)) ? '1 : occ[LVL_W-1:0];
   end else begin : g_lvl_direct
      assign occ_lvl = LVL_W'(occ);
   end

   assign lvl = (tx_drain || rx_drain) ? rem[LVL_W-1:0] : occ_lvl;

   always_comb begin
      stat_rdata                 = '0;
      stat_rdata[STAT_CODE +: 2] = 2'(SIZE_CODE);
      stat_rdata[LVL_W-1:0]      = lvl;
   end

   // R9: while draining, status level equals the bytes still owed
   p_drain_level_r9: assert property (@(posedge clk) disable iff (!rst_n)
      (tx_drain || rx_drain) |-> (stat_rdata[LVL_W-1:0] == rem[LVL_W-1:0]));
   // R6: transmit ready implies room for a full threshold burst
   p_tx_ready_room_r6: assert property (@(posedge clk) disable iff (!rst_n)
      tx_ready |-> (int'(tx_cnt) + int'(tx_thr) <= DEPTH));
   // R7: receive ready implies a full threshold burst is stored
   p_rx_ready_data_r7: assert property (@(posedge clk) disable iff (!rst_n)
      rx_ready |-> (rx_cnt >= CNTW'(rx_thr)));
   // R10: only one direction signals at a time
   p_one_dir_r10: assert property (@(posedge clk) disable iff (!rst_n)
      $onehot0({tx_ready || tx_drain, rx_ready || rx_drain}));
endmodule

// File: tb/test_byte_fifo_pair.sv
module test_byte_fifo_pair;
   localparam int CW = 8;

   logic clk = 1'b0, rst_n = 1'b0;
   logic cfg_we = 1'b0; logic [15:0] cfg_wdata = '0;
   logic [15:0] cfg_rdata, stat_rdata;
   logic xfer_load = 1'b0, xfer_is_tx = 1'b0; logic [CW-1:0] xfer_len = '0;
   logic host_tx_we = 1'b0; logic [7:0] host_tx_data = '0;
   logic host_rx_re = 1'b0; logic [7:0] host_rx_data;
   logic eng_tx_re = 1'b0; logic [7:0] eng_tx_data; logic eng_tx_empty;
   logic eng_rx_we = 1'b0; logic [7:0] eng_rx_data = '0; logic eng_rx_full;
   logic tx_ready, tx_drain, rx_ready, rx_drain;

   int total = 0, bad = 0;

   always #4 clk = ~clk; // 8 time units per period: 125 MHz at 1 ns units

   byte_fifo_pair #(.SIZE_CODE(1), .CW(CW)) i_byte_fifo_pair (.*);

   task automatic chk(input string tag, input int act, input int exp);
      total++;
      if (act != exp) begin
         bad++;
         $display("FAIL %s: actual=%0d expected=%0d", tag, act, exp);
      end
   endtask

   task automatic cfg_wr(input logic [15:0] v);
      cfg_we = 1'b1; cfg_wdata = v; @(negedge clk); cfg_we = 1'b0;
   endtask
   task automatic xload(input logic tx, input int n);
      xfer_load = 1'b1; xfer_is_tx = tx; xfer_len = CW'(n);
      @(negedge clk); xfer_load = 1'b0;
   endtask
   task automatic hpush(input int n, input int base);
      for (int i = 0; i < n; i++) begin
         host_tx_we = 1'b1; host_tx_data = 8'(base + i); @(negedge clk);
      end
      host_tx_we = 1'b0;
   endtask
   task automatic epush(input int n, input int base);
      for (int i = 0; i < n; i++) begin
         eng_rx_we = 1'b1; eng_rx_data = 8'(base + i); @(negedge clk);
      end
      eng_rx_we = 1'b0;
   endtask
   task automatic hpop(input int n);
      for (int i = 0; i < n; i++) begin
         host_rx_re = 1'b1; @(negedge clk);
      end
      host_rx_re = 1'b0;
   endtask

   function automatic int evts();
      return {28'd0, tx_ready, tx_drain, rx_ready, rx_drain};
   endfunction

   // {is_tx, thr_m1[6], len[8], moves[8], exp_ready, exp_drain, exp_level[6]}
   localparam logic [30:0] VEC [12] = '{
      {1'b1, 6'd3,  8'd10, 8'd0,  1'b1, 1'b0, 6'd0},
      {1'b1, 6'd3,  8'd3,  8'd0,  1'b0, 1'b1, 6'd3},
      {1'b1, 6'd3,  8'd20, 8'd14, 1'b0, 1'b0, 6'd14},
      {1'b1, 6'd3,  8'd16, 8'd13, 1'b0, 1'b1, 6'd3},
      {1'b1, 6'd3,  8'd17, 8'd14, 1'b0, 1'b0, 6'd14},
      {1'b0, 6'd3,  8'd10, 8'd3,  1'b0, 1'b0, 6'd3},
      {1'b0, 6'd3,  8'd10, 8'd4,  1'b1, 1'b0, 6'd4},
      {1'b0, 6'd7,  8'd5,  8'd5,  1'b0, 1'b1, 6'd5},
      {1'b0, 6'd7,  8'd5,  8'd4,  1'b0, 1'b0, 6'd4},
      {1'b0, 6'd63, 8'd20, 8'd16, 1'b1, 1'b0, 6'd16},
      {1'b1, 6'd0,  8'd1,  8'd0,  1'b1, 1'b0, 6'd0},
      {1'b1, 6'd3,  8'd0,  8'd0,  1'b0, 1'b0, 6'd0}
   };

   initial begin
      repeat (200000) @(posedge clk);
      total++; bad++;
      $display("FAIL watchdog: actual=timeout expected=finish");
      $display("test done: total=%0d bad=%0d", total, bad);
      $finish;
   end

   initial begin
      repeat (3) @(negedge clk);
      rst_n = 1'b1;
      @(negedge clk);

      // Reset state
      chk("R4 cfg reset", cfg_rdata, 0);
      chk("R1 size code at reset", stat_rdata, 16'h4000);
      chk("R10 no events at reset", evts(), 0);

      // R4 layout, clear bits read zero
      cfg_wr(16'hFFFF);
      chk("R4 readback", cfg_rdata, 16'hBFBF);

      // R1 depth 16, R2 order, R3 overflow dropped
      cfg_wr(16'h4040);
      xload(1'b1, 40);
      hpush(20, 0);
      chk("R1 depth holds 16", stat_rdata, 16'h4010);
      for (int i = 0; i < 16; i++) begin
         chk("R2 tx order", eng_tx_data, i);
         eng_tx_re = 1'b1; @(negedge clk); eng_tx_re = 1'b0;
      end
      chk("R3 extra pushes dropped", eng_tx_empty, 1);

      // R2 receive order, R3 pop on empty ignored
      cfg_wr(16'h4040);
      xload(1'b0, 3);
      epush(3, 8'h11);
      for (int i = 0; i < 3; i++) begin
         chk("R2 rx order", host_rx_data, 8'h11 + i);
         hpop(1);
      end
      hpop(1);
      chk("R3 empty pop level", stat_rdata[5:0], 0);
      epush(1, 8'hA5);
      chk("R3 empty pop no advance", host_rx_data, 8'hA5);

      // R5 selective clear
      cfg_wr(16'h4040);
      xload(1'b1, 10);
      hpush(2, 0);
      epush(3, 0);
      cfg_wr(16'h4000);
      chk("R5 tx untouched by rx clear", stat_rdata, 16'h4002);
      xload(1'b0, 10);
      chk("R5 rx emptied", stat_rdata, 16'h4000);
      chk("R5 rx no ready", rx_ready, 0);

      // R8/R9/R10 receive drain and zero floor
      cfg_wr(16'h4343);
      xload(1'b0, 2);
      epush(2, 0);
      chk("R8 rx drain", rx_drain, 1);
      chk("R9 drain level", stat_rdata, 16'h4002);
      hpop(2);
      chk("R10 zero count quiet", evts(), 0);
      epush(5, 0);
      chk("R10 no ready at zero", rx_ready, 0);
      hpop(1);
      chk("R10 no wrap below zero", evts(), 0);
      chk("R10 level after extra pop", stat_rdata[5:0], 4);

      // R6 ready then R8 drain as count falls
      xload(1'b1, 6);
      chk("R6 tx ready", tx_ready, 1);
      hpush(3, 0);
      chk("R8 tx drain", tx_drain, 1);
      chk("R9 tx drain level", stat_rdata[5:0], 3);

      // Table of transfers (R6 R7 R8 R9 R11)
      for (int r = 0; r < 12; r++) begin
         logic [30:0] v;
         int thm, ln, mv;
         v   = VEC[r];
         thm = int'(v[29:24]);
         ln  = int'(v[23:16]);
         mv  = int'(v[15:8]);
         cfg_wr(16'h4040 | 16'(thm << 8) | 16'(thm));
         xload(v[30], ln);
         if (v[30]) hpush(mv, 0); else epush(mv, 0);
         if (v[30]) begin
            chk($sformatf("R6 row %0d tx_ready", r), tx_ready, int'(v[7]));
            chk($sformatf("R8 row %0d tx_drain", r), tx_drain, int'(v[6]));
         end else begin
            chk($sformatf("R7/R11 row %0d rx_ready", r), rx_ready, int'(v[7]));
            chk($sformatf("R8 row %0d rx_drain", r), rx_drain, int'(v[6]));
         end
         chk($sformatf("R9 row %0d level", r), stat_rdata[5:0], int'(v[5:0]));
      end

      $display("test done: total=%0d bad=%0d", total, bad);
      $finish;
   end
endmodule